// File: doc/BRIEF.md
# Single-Entry Branch Target Predictor

This block sits beside an in-order fetch unit and remembers exactly one branch. When the fetch address equals the remembered branch address, the block reports a hit in the same cycle and supplies the remembered destination. Fetch can then be redirected at once, so a taken branch costs no one-cycle bubble. Tight loops closed by a backward branch benefit most.

The execute stage reports each resolved branch. The report carries the branch address, its destination, whether it was taken, and whether it was mispredicted. Only a taken branch whose destination lies strictly below its own address fills the entry, and a newer fill overwrites an older one. The entry is emptied in three cases: a fence.i strobe, a trap strobe, or a report of a mispredicted branch that was not taken. If a fill and an emptying event arrive in the same cycle, emptying takes priority.

Top module: `btp_top`

## Requirements
- R1: After reset the entry is empty: predHit is 0 for every fetch address.
- R2: predHit is 1 only when the entry holds a branch and fetchAddr equals the stored branch address in every bit. When predHit is 0, predTarget is all zeros.
- R3: A report with resValid=1, resTaken=1 and resTarget less than resAddr (unsigned) fills the entry. From the next cycle, fetching resAddr gives predHit=1 with predTarget=resTarget.
- R4: A later qualifying fill replaces the stored branch. The old branch address no longer hits.
- R5: A taken report with resTarget greater than or equal to resAddr leaves the entry unchanged. A not-taken report with resMispredict=0 also leaves it unchanged.
- R6: A report with resValid=1, resTaken=0 and resMispredict=1 empties the entry from the next cycle.
- R7: fenceI=1 empties the entry from the next cycle.
- R8: trap=1 empties the entry from the next cycle.
- R9: When a fill and an emptying event occur in the same cycle, the entry ends up empty.
- R10: While resValid=0, the report fields have no effect on the entry.
- R11: The hit is combinational. predHit and predTarget follow fetchAddr within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchAddr | input | ADDR_W | Address being fetched this cycle |
| resValid | input | 1 | A branch resolution report is present |
| resAddr | input | ADDR_W | Address of the resolved branch |
| resTarget | input | ADDR_W | Destination of the resolved branch |
| resTaken | input | 1 | The resolved branch was taken |
| resMispredict | input | 1 | The resolved branch was mispredicted |
| fenceI | input | 1 | Instruction fence strobe |
| trap | input | 1 | Trap entry strobe |
| predHit | output | 1 | Fetch address matches the stored branch |
| predTarget | output | ADDR_W | Predicted destination, zero when no hit |

## Verification
A wrong stored state shows at the ports the first time the affected address is fetched. Three kinds of error are visible: a valid flag that survives an emptying event, a branch address latched from the wrong report, or a destination that is stale. The bench therefore probes fetchAddr in the cycle right after every report or strobe. It checks both the address that was just written and the previously stored address. This catches a missed overwrite, a fill from a forward branch, or a lost priority within one cycle of the cause.

// File: rtl/btp_pkg.sv
package btp_pkg;
  // Strobes from control to the entry datapath
  typedef struct packed {
    logic load;   // capture a new branch into the entry
    logic clear;  // drop the entry
  } btpCtl_t;
endpackage

// File: rtl/btp_ctrl.sv
module btp_ctrl
  import btp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic              resTaken,
  input  logic              resMispredict,
  input  logic              fenceI,
  input  logic              trap,
  output btpCtl_t           ctl
);
  logic isBackward;
  logic allocReq;
  logic missReq;

  always_comb begin
    isBackward = resTarget < resAddr;
    allocReq   = resValid && resTaken && isBackward;
    missReq    = resValid && !resTaken && resMispredict;
    ctl.clear  = fenceI || trap || missReq;
    ctl.load   = allocReq && !ctl.clear;
  end

  AST_FWD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken && (resTarget >= resAddr)) |-> !ctl.load); // R5
  AST_STROBE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (fenceI || trap) |-> !ctl.load); // R9
  AST_IDLE_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    (!resValid && !fenceI && !trap) |-> (!ctl.load && !ctl.clear)); // R10
endmodule

// File: rtl/btp_entry.sv
module btp_entry
  import btp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  btpCtl_t           ctl,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              predHit,
  output logic [ADDR_W-1:0] predTarget
);
  logic              validQ;
  logic [ADDR_W-1:0] srcQ;
  logic [ADDR_W-1:0] tgtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      srcQ   <= '0;
      tgtQ   <= '0;
    end else if (ctl.clear) begin
      validQ <= 1'b0;
    end else if (ctl.load) begin
      validQ <= 1'b1;
      srcQ   <= resAddr;
      tgtQ   <= resTarget;
    end
  end

  always_comb begin
    predHit    = validQ && (fetchAddr == srcQ);
    predTarget = predHit ? tgtQ : '0;
  end

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (validQ && srcQ == $past(resAddr) && tgtQ == $past(resTarget))); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> !predHit); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.clear) |=> ($stable(validQ) && $stable(srcQ) && $stable(tgtQ))); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predTarget == '0)); // R2
endmodule

// File: rtl/btp_top.sv
module btp_top
  import btp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic              resTaken,
  input  logic              resMispredict,
  input  logic              fenceI,
  input  logic              trap,
  output logic              predHit,
  output logic [ADDR_W-1:0] predTarget
);
  btpCtl_t ctl;

  btp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resAddr(resAddr),
    .resTarget(resTarget), .resTaken(resTaken), .resMispredict(resMispredict),
    .fenceI(fenceI), .trap(trap), .ctl(ctl)
  );

  btp_entry #(.ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rstN(rstN), .ctl(ctl), .resAddr(resAddr), .resTarget(resTarget),
    .fetchAddr(fetchAddr), .predHit(predHit), .predTarget(predTarget)
  );

  AST_STROBE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fenceI || trap) |=> !predHit); // R7
endmodule

// File: tb/btp_top_tb.sv
module btp_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        resValid = 1'b0;
  logic [31:0] resAddr = '0;
  logic [31:0] resTarget = '0;
  logic        resTaken = 1'b0;
  logic        resMispredict = 1'b0;
  logic        fenceI = 1'b0;
  logic        trap = 1'b0;
  logic        predHit;
  logic [31:0] predTarget;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  btp_top #(.ADDR_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .resValid(resValid),
    .resAddr(resAddr), .resTarget(resTarget), .resTaken(resTaken),
    .resMispredict(resMispredict), .fenceI(fenceI), .trap(trap),
    .predHit(predHit), .predTarget(predTarget)
  );

  task automatic probe(input logic [31:0] fa, input logic expHit,
                       input logic [31:0] expTgt, input string req);
    fetchAddr = fa;
    #1;
    checks++;
    if (predHit !== expHit || predTarget !== expTgt) begin
      fails++;
      $display("FAIL %s: fetch %h got hit=%b tgt=%h expected hit=%b tgt=%h",
               req, fa, predHit, predTarget, expHit, expTgt);
    end
  endtask

  // one cycle of stimulus, applied at negedge, removed at next negedge
  task automatic pulse(input logic v, input logic [31:0] a, input logic [31:0] t,
                       input logic tk, input logic mp, input logic fi, input logic tr);
    @(negedge clk);
    resValid = v; resAddr = a; resTarget = t; resTaken = tk;
    resMispredict = mp; fenceI = fi; trap = tr;
    @(negedge clk);
    resValid = 0; resTaken = 0; resMispredict = 0; fenceI = 0; trap = 0;
  endtask

  task automatic t_reset;
    probe(32'h0, 0, 32'h0, "R1");
    probe(32'h100, 0, 32'h0, "R1");
  endtask

  task automatic t_alloc;
    pulse(1, 32'h200, 32'h180, 1, 0, 0, 0);
    probe(32'h200, 1, 32'h180, "R3");
    probe(32'h204, 0, 32'h0, "R2");
    probe(32'h200, 1, 32'h180, "R11");
    probe(32'h201, 0, 32'h0, "R2");
  endtask

  task automatic t_forward;
    pulse(1, 32'h300, 32'h340, 1, 0, 0, 0);
    probe(32'h300, 0, 32'h0, "R5");
    probe(32'h200, 1, 32'h180, "R5");
    pulse(1, 32'h400, 32'h400, 1, 0, 0, 0);
    probe(32'h400, 0, 32'h0, "R5");
    pulse(1, 32'h200, 32'h100, 0, 0, 0, 0);
    probe(32'h200, 1, 32'h180, "R5");
  endtask

  task automatic t_novalid;
    pulse(0, 32'h700, 32'h10, 1, 0, 0, 0);
    probe(32'h700, 0, 32'h0, "R10");
    probe(32'h200, 1, 32'h180, "R10");
    pulse(0, 32'h200, 32'h0, 0, 1, 0, 0);
    probe(32'h200, 1, 32'h180, "R10");
  endtask

  task automatic t_overwrite;
    pulse(1, 32'h500, 32'h100, 1, 0, 0, 0);
    probe(32'h500, 1, 32'h100, "R4");
    probe(32'h200, 0, 32'h0, "R4");
  endtask

  task automatic t_mispredict;
    pulse(1, 32'h500, 32'h100, 0, 1, 0, 0);
    probe(32'h500, 0, 32'h0, "R6");
  endtask

  task automatic t_fence;
    pulse(1, 32'h800, 32'h20, 1, 0, 0, 0);
    probe(32'h800, 1, 32'h20, "R7");
    pulse(0, 32'h0, 32'h0, 0, 0, 1, 0);
    probe(32'h800, 0, 32'h0, "R7");
  endtask

  task automatic t_trap;
    pulse(1, 32'h900, 32'h40, 1, 0, 0, 0);
    probe(32'h900, 1, 32'h40, "R8");
    pulse(0, 32'h0, 32'h0, 0, 0, 0, 1);
    probe(32'h900, 0, 32'h0, "R8");
  endtask

  task automatic t_priority;
    pulse(1, 32'h600, 32'h10, 1, 0, 0, 1);
    probe(32'h600, 0, 32'h0, "R9");
    pulse(1, 32'hA00, 32'h50, 1, 0, 0, 0);
    pulse(1, 32'hB00, 32'h60, 1, 0, 1, 0);
    probe(32'hB00, 0, 32'h0, "R9");
    probe(32'hA00, 0, 32'h0, "R9");
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_forward();
    t_novalid();
    t_overwrite();
    t_mispredict();
    t_fence();
    t_trap();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule